// File: doc/BRIEF.md
# Latency-Based Pipeline Interlock Unit

This block decides, cycle by cycle, whether the instruction waiting at the issue point of an in-order pipeline may leave. It keeps a short history of the instructions issued in the last few cycles that write a register, with each one's class (load, integer ALU, floating-point ALU) and destination. It compares the waiting instruction's source registers against that history. The number of cycles an instruction must wait behind a producer depends on the pair of producer class and operand use (ALU-type operand, store data, or branch condition). The floating-point add takes four pipelined execute stages. Loads, stores and integer operations take one.

A branch has one architectural delay slot. The cycle right after a branch issues belongs to that slot. Only an instruction that the front end marks as the delay-slot fill may issue there, and any other instruction waits until the slot has passed. The waiting instruction is held at the inputs, and the block re-evaluates it every cycle until it is accepted.

Top module: `issue_interlock`

## Requirements
- R1: After reset the history is empty and no delay slot is pending, so the first instruction issues with no stall. A reset in the middle of a hazard cancels it.
- R2: A load followed by a consumer that reads the loaded register as an ALU-type operand needs 1 stall cycle when back to back. ALU-type operands are an integer or FP ALU source, a load address or a store address. If the consumer reads it as store data (operand B of a store), 0 stall cycles are needed. Each cycle of separation removes one stall cycle.
- R3: An FP ALU result read as an ALU-type operand needs 3 stall cycles. Read as store data, it needs 2.
- R4: A branch reads its condition from operand A one cycle earlier than an ALU does. An integer ALU result needs 0 stalls for ALU-type use or store data and 1 for a branch. A load result needs 2 stalls for a branch, and an FP ALU result needs 4.
- R5: In the cycle after a branch issues, an instruction with in_slot=0 is stalled for that one cycle. An instruction with in_slot=1 may issue there, subject to its data hazards. A cycle with no valid instruction still consumes the slot. At any other time in_slot has no effect.
- R6: Register id 0 never causes a stall, as source or as destination. An instruction with dst_vld=0, or of class store, branch or nop, creates no hazard.
- R7: stall and issue_ok are both low when in_valid is low. They are never high together. issue_ok is high exactly when in_valid is high and stall is low.
- R8: Register ids are 6 bits wide. Bit 5 set selects the FP file, so id 32 (first FP register) is an ordinary tracked register.
- R9: The array-add loop (load, FP add, store, index decrement, branch) takes 10 cycles per iteration in program order. It takes 6 cycles when the decrement is moved after the load and the store is placed in the delay slot.
- R10: When both operands have hazards, the stall lasts until the longer of the two requirements is met.
- Class encoding of in_cls: 0 nop, 1 load, 2 store, 3 integer ALU, 4 FP ALU, 5 branch. Operand A is the address for loads and stores and the condition for branches. Operand B is the store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is waiting at the issue point |
| in_cls | input | 3 | Class of the waiting instruction |
| in_slot | input | 1 | Instruction is the fill of a branch delay slot |
| src_a | input | 6 | Operand A register id |
| src_a_vld | input | 1 | Operand A is read |
| src_b | input | 6 | Operand B register id |
| src_b_vld | input | 1 | Operand B is read |
| dst | input | 6 | Destination register id |
| dst_vld | input | 1 | Instruction writes dst |
| stall | output | 1 | Waiting instruction must be held this cycle |
| issue_ok | output | 1 | Waiting instruction is accepted this cycle |

## Verification
The assertions check on every cycle these properties: the output pair stays exclusive and quiet when idle, a back-to-back load to ALU dependence always stalls, an FP result read three cycles later still stalls, a non-fill instruction right after a branch is held, and operands naming only register 0 never stall. The exact stall counts for every producer and use pair, including separation by idle cycles, dual-operand hazards, reset cancelling a hazard and the per-iteration cycle counts of the two loop schedules, are shown only by the bench's scenarios.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CL_NOP    = 3'd0,
    CL_LOAD   = 3'd1,
    CL_STORE  = 3'd2,
    CL_IALU   = 3'd3,
    CL_FPALU  = 3'd4,
    CL_BRANCH = 3'd5
  } icls_e;

  typedef enum logic [1:0] {
    USE_ALU    = 2'd0,
    USE_STDATA = 2'd1,
    USE_BRANCH = 2'd2
  } use_e;

  // Required bubbles between producer and consumer.
  localparam int GAP_LD_ALU = 1;
  localparam int GAP_LD_ST  = 0;
  localparam int GAP_FP_ALU = 3;
  localparam int GAP_FP_ST  = 2;
  localparam int GAP_IA_ALU = 0;
  localparam int GAP_IA_ST  = 0;
  localparam int BR_EARLY   = 1;   // branch resolves one stage before an ALU reads
  localparam int GAP_LD_BR  = GAP_LD_ALU + BR_EARLY;
  localparam int GAP_FP_BR  = GAP_FP_ALU + BR_EARLY;
  localparam int GAP_IA_BR  = GAP_IA_ALU + BR_EARLY;

  localparam int GAP_M1 = (GAP_LD_BR > GAP_FP_BR) ? GAP_LD_BR : GAP_FP_BR;
  localparam int GAP_M2 = (GAP_M1 > GAP_IA_BR) ? GAP_M1 : GAP_IA_BR;
  localparam int GAP_M3 = (GAP_M2 > GAP_FP_ALU) ? GAP_M2 : GAP_FP_ALU;
  localparam int HIST_DEPTH = (GAP_M3 < 1) ? 1 : GAP_M3;

  function automatic int need_gap(icls_e p, use_e u);
    int g;
    g = 0;
    case (p)
      CL_LOAD: begin
        case (u)
          USE_STDATA: g = GAP_LD_ST;
          USE_BRANCH: g = GAP_LD_BR;
          default:    g = GAP_LD_ALU;
        endcase
      end
      CL_FPALU: begin
        case (u)
          USE_STDATA: g = GAP_FP_ST;
          USE_BRANCH: g = GAP_FP_BR;
          default:    g = GAP_FP_ALU;
        endcase
      end
      CL_IALU: begin
        case (u)
          USE_STDATA: g = GAP_IA_ST;
          USE_BRANCH: g = GAP_IA_BR;
          default:    g = GAP_IA_ALU;
        endcase
      end
      default: g = 0;
    endcase
    return g;
  endfunction

  function automatic logic writes_reg(icls_e c);
    return (c == CL_LOAD) || (c == CL_IALU) || (c == CL_FPALU);
  endfunction

  // Operand role: A is address/condition/ALU source, B is store data or ALU source.
  function automatic use_e use_for(icls_e c, logic is_b);
    use_e u;
    if (!is_b && c == CL_BRANCH)     u = USE_BRANCH;
    else if (is_b && c == CL_STORE)  u = USE_STDATA;
    else                             u = USE_ALU;
    return u;
  endfunction

endpackage

// File: rtl/ilk_hist.sv
module ilk_hist
  import ilk_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  icls_e            push_cls,
  input  logic [REG_W-1:0] push_dst,
  output logic             h_vld [DEPTH],
  output icls_e            h_cls [DEPTH],
  output logic [REG_W-1:0] h_dst [DEPTH]
);

  // Stage i holds the producer issued i+1 cycles ago (or a bubble).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        h_vld[i] <= 1'b0;
        h_cls[i] <= CL_NOP;
        h_dst[i] <= '0;
      end
    end else begin
      h_vld[0] <= push;
      h_cls[0] <= push_cls;
      h_dst[0] <= push_dst;
      for (int i = 1; i < DEPTH; i++) begin
        h_vld[i] <= h_vld[i-1];
        h_cls[i] <= h_cls[i-1];
        h_dst[i] <= h_dst[i-1];
      end
    end
  end

endmodule

// File: rtl/ilk_opcheck.sv
module ilk_opcheck
  import ilk_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int DEPTH = 4
) (
  input  logic             src_vld,
  input  logic [REG_W-1:0] src,
  input  use_e             use_sel,
  input  logic             h_vld [DEPTH],
  input  icls_e            h_cls [DEPTH],
  input  logic [REG_W-1:0] h_dst [DEPTH],
  output logic             hz
);

  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = h_vld[i] && (h_dst[i] == src) && (i < need_gap(h_cls[i], use_sel));
  end

  assign hz = src_vld && (src != '0) && (|hit);

endmodule

// File: rtl/ilk_slot.sv
module ilk_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic br_go,
  output logic slot_open
);

  // The cycle after a branch issues is its delay slot, used or not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_open <= 1'b0;
    else        slot_open <= br_go;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int DEPTH = HIST_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_cls,
  input  logic             in_slot,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_a_vld,
  input  logic [REG_W-1:0] src_b,
  input  logic             src_b_vld,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_vld,
  output logic             stall,
  output logic             issue_ok
);

  localparam int NOPS = 2;

  icls_e            cls;
  logic             h_vld [DEPTH];
  icls_e            h_cls [DEPTH];
  logic [REG_W-1:0] h_dst [DEPTH];

  logic [REG_W-1:0] op_src [NOPS];
  logic             op_vld [NOPS];
  logic [NOPS-1:0]  op_hz;

  // Named events for the checker
  logic hz_a, hz_b, slot_open, slot_block, push, br_go;

  assign cls       = icls_e'(in_cls);
  assign op_src[0] = src_a;
  assign op_vld[0] = src_a_vld;
  assign op_src[1] = src_b;
  assign op_vld[1] = src_b_vld;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    ilk_opcheck #(.REG_W(REG_W), .DEPTH(DEPTH)) u_chk (
      .src_vld (op_vld[k]),
      .src     (op_src[k]),
      .use_sel (use_for(cls, k == 1)),
      .h_vld   (h_vld),
      .h_cls   (h_cls),
      .h_dst   (h_dst),
      .hz      (op_hz[k])
    );
  end

  assign hz_a       = op_hz[0];
  assign hz_b       = op_hz[1];
  assign slot_block = slot_open && !in_slot;
  assign stall      = in_valid && (hz_a || hz_b || slot_block);
  assign issue_ok   = in_valid && !stall;
  assign push       = issue_ok && dst_vld && writes_reg(cls) && (dst != '0);
  assign br_go      = issue_ok && (cls == CL_BRANCH);

  ilk_hist #(.REG_W(REG_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_cls (cls),
    .push_dst (dst),
    .h_vld    (h_vld),
    .h_cls    (h_cls),
    .h_dst    (h_dst)
  );

  ilk_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_go     (br_go),
    .slot_open (slot_open)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk
  import ilk_pkg::*;
#(
  parameter int REG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_cls,
  input logic             in_slot,
  input logic [REG_W-1:0] src_a,
  input logic             src_a_vld,
  input logic [REG_W-1:0] src_b,
  input logic             src_b_vld,
  input logic [REG_W-1:0] dst,
  input logic             dst_vld,
  input logic             stall,
  input logic             issue_ok,
  input logic             slot_block
);

  logic [1:0] age;   // cycles since reset, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!stall && !issue_ok));

  assert_out_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, issue_ok}));

  assert_load_alu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd1) && $past(issue_ok && in_cls == CL_LOAD && dst_vld && dst != '0)
     && in_valid && in_cls == CL_IALU && src_a_vld && src_a == $past(dst))
    |-> stall);

  assert_fp_alu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && $past(issue_ok && in_cls == CL_FPALU && dst_vld && dst != '0, 3)
     && in_valid && in_cls == CL_FPALU && src_a_vld && src_a == $past(dst, 3))
    |-> stall);

  assert_delay_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd1) && $past(issue_ok && in_cls == CL_BRANCH) && in_valid && !in_slot)
    |-> stall);

  assert_reg_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !slot_block && (!src_a_vld || src_a == '0) && (!src_b_vld || src_b == '0))
    |-> !stall);

endmodule

bind issue_interlock issue_interlock_chk #(.REG_W(REG_W)) u_ilk_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_cls     (in_cls),
  .in_slot    (in_slot),
  .src_a      (src_a),
  .src_a_vld  (src_a_vld),
  .src_b      (src_b),
  .src_b_vld  (src_b_vld),
  .dst        (dst),
  .dst_vld    (dst_vld),
  .stall      (stall),
  .issue_ok   (issue_ok),
  .slot_block (slot_block)
);

// File: tb/sim_issue_interlock.sv
`timescale 1ns/1ps
module sim_issue_interlock;

  localparam logic [2:0] NOP = 3'd0, LD = 3'd1, ST = 3'd2, IA = 3'd3, FP = 3'd4, BR = 3'd5;
  localparam int NV = 12;
  // {producer class, consumer class, consumer reads via B, 2'b0, expected stalls}
  localparam logic [11:0] VEC [NV] = '{
    {LD, IA, 1'b0, 2'd0, 3'd1},
    {LD, ST, 1'b1, 2'd0, 3'd0},
    {LD, ST, 1'b0, 2'd0, 3'd1},
    {LD, BR, 1'b0, 2'd0, 3'd2},
    {LD, FP, 1'b1, 2'd0, 3'd1},
    {FP, FP, 1'b0, 2'd0, 3'd3},
    {FP, ST, 1'b1, 2'd0, 3'd2},
    {FP, BR, 1'b0, 2'd0, 3'd4},
    {IA, IA, 1'b1, 2'd0, 3'd0},
    {IA, BR, 1'b0, 2'd0, 3'd1},
    {IA, LD, 1'b0, 2'd0, 3'd0},
    {ST, IA, 1'b0, 2'd0, 3'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_slot = 1'b0;
  logic [2:0] in_cls = '0;
  logic [5:0] src_a = '0, src_b = '0, dst = '0;
  logic       src_a_vld = 1'b0, src_b_vld = 1'b0, dst_vld = 1'b0;
  logic       stall, issue_ok;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  issue_interlock u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_slot(in_slot),
    .src_a(src_a), .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
    .dst(dst), .dst_vld(dst_vld), .stall(stall), .issue_ok(issue_ok)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic present(input logic [2:0] c, input logic [5:0] a, input logic av,
                         input logic [5:0] b, input logic bv, input logic [5:0] d,
                         input logic dv, input logic sl, output int ns, output int at);
    in_valid = 1'b1; in_cls = c; src_a = a; src_a_vld = av; src_b = b; src_b_vld = bv;
    dst = d; dst_vld = dv; in_slot = sl;
    ns = 0;
    #1;
    while (!issue_ok) begin
      ns++;
      @(negedge clk);
      #1;
    end
    at = cyc;
    @(negedge clk);
    in_valid = 1'b0; in_slot = 1'b0; src_a_vld = 1'b0; src_b_vld = 1'b0; dst_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int ns, t, t0, t1;
    string tag;
    logic [5:0] pd;
    repeat (3) @(negedge clk);
    #1;
    check("R1 stall in reset", int'(stall), 0);
    check("R7 issue_ok in reset", int'(issue_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    present(IA, 6'd9, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R1 first issue", ns, 0);
    idle(6);

    // Table of producer/consumer pairs, back to back
    for (int k = 0; k < NV; k++) begin
      logic [2:0] pc, cc;
      pc = VEC[k][11:9];
      cc = VEC[k][8:6];
      pd = (pc == FP) ? 6'd40 : 6'd5;
      if (cc == BR)       tag = "R4 pair";
      else if (pc == LD)  tag = "R2 pair";
      else if (pc == FP)  tag = "R3 pair";
      else if (pc == IA)  tag = "R4 pair";
      else                tag = "R6 pair";
      present(pc, 6'd9, 1'b1, 6'd10, 1'b1, pd, 1'b1, 1'b0, ns, t);
      if (VEC[k][5])
        present(cc, 6'd7, 1'b1, pd, 1'b1, 6'd0, 1'b0, 1'b0, ns, t);
      else
        present(cc, pd, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
      check($sformatf("%s row %0d", tag, k), ns, int'(VEC[k][2:0]));
      idle(6);
    end

    // Idle cycle with a dependent pattern on the inputs, then gap of one
    present(LD, 6'd9, 1'b1, 6'd0, 1'b0, 6'd5, 1'b1, 1'b0, ns, t);
    in_cls = IA; src_a = 6'd5; src_a_vld = 1'b1;
    #1;
    check("R7 idle stall", int'(stall), 0);
    check("R7 idle issue_ok", int'(issue_ok), 0);
    @(negedge clk);
    present(IA, 6'd5, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R2 load gap 1", ns, 0);
    idle(6);

    present(FP, 6'd33, 1'b1, 6'd34, 1'b1, 6'd40, 1'b1, 1'b0, ns, t);
    idle(1);
    present(FP, 6'd40, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R3 fp gap 1", ns, 2);
    idle(6);

    // Both operands hazarded
    present(FP, 6'd33, 1'b1, 6'd34, 1'b1, 6'd40, 1'b1, 1'b0, ns, t);
    present(LD, 6'd9, 1'b1, 6'd0, 1'b0, 6'd33, 1'b1, 1'b0, ns, t);
    present(FP, 6'd33, 1'b1, 6'd40, 1'b1, 6'd0, 1'b0, 1'b0, ns, t);
    check("R10 dual operand", ns, 2);
    idle(6);

    // Register zero and non-writing producers
    present(IA, 6'd9, 1'b1, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0, ns, t);
    present(IA, 6'd0, 1'b1, 6'd0, 1'b1, 6'd0, 1'b0, 1'b0, ns, t);
    check("R6 register zero", ns, 0);
    idle(6);
    present(LD, 6'd9, 1'b1, 6'd0, 1'b0, 6'd5, 1'b0, 1'b0, ns, t);
    present(IA, 6'd5, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R6 dst_vld low", ns, 0);
    idle(6);
    present(LD, 6'd9, 1'b1, 6'd0, 1'b0, 6'd32, 1'b1, 1'b0, ns, t);
    present(FP, 6'd32, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R8 fp id 32 tracked", ns, 1);
    idle(6);

    // Delay slot
    present(BR, 6'd9, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    present(IA, 6'd9, 1'b1, 6'd0, 1'b0, 6'd11, 1'b1, 1'b0, ns, t);
    check("R5 non-fill after branch", ns, 1);
    idle(6);
    present(BR, 6'd9, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    present(IA, 6'd9, 1'b1, 6'd0, 1'b0, 6'd11, 1'b1, 1'b1, ns, t);
    check("R5 fill after branch", ns, 0);
    idle(6);
    present(BR, 6'd9, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    idle(1);
    present(IA, 6'd9, 1'b1, 6'd0, 1'b0, 6'd11, 1'b1, 1'b0, ns, t);
    check("R5 empty slot consumed", ns, 0);
    idle(6);
    present(LD, 6'd9, 1'b1, 6'd0, 1'b0, 6'd5, 1'b1, 1'b0, ns, t);
    present(IA, 6'd5, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b1, ns, t);
    check("R5 fill flag ignored off-slot", ns, 1);
    idle(6);

    // Reset cancels a pending hazard
    present(FP, 6'd33, 1'b1, 6'd34, 1'b1, 6'd40, 1'b1, 1'b0, ns, t);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    present(FP, 6'd40, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    check("R1 reset clears history", ns, 0);
    idle(6);

    // Array-add loop, program order: ld, fadd, sd, dec, bnez
    present(LD, 6'd1, 1'b1, 6'd0, 1'b0, 6'd32, 1'b1, 1'b0, ns, t0);
    present(FP, 6'd32, 1'b1, 6'd34, 1'b1, 6'd36, 1'b1, 1'b0, ns, t);
    present(ST, 6'd1, 1'b1, 6'd36, 1'b1, 6'd0, 1'b0, 1'b0, ns, t);
    present(IA, 6'd1, 1'b1, 6'd0, 1'b0, 6'd1, 1'b1, 1'b0, ns, t);
    present(BR, 6'd1, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    present(LD, 6'd1, 1'b1, 6'd0, 1'b0, 6'd32, 1'b1, 1'b0, ns, t1);
    check("R9 unscheduled iteration", t1 - t0, 10);
    idle(6);

    // Reordered: ld, dec, fadd, bnez, sd in delay slot
    present(LD, 6'd1, 1'b1, 6'd0, 1'b0, 6'd32, 1'b1, 1'b0, ns, t0);
    present(IA, 6'd1, 1'b1, 6'd0, 1'b0, 6'd1, 1'b1, 1'b0, ns, t);
    present(FP, 6'd32, 1'b1, 6'd34, 1'b1, 6'd36, 1'b1, 1'b0, ns, t);
    present(BR, 6'd1, 1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0, ns, t);
    present(ST, 6'd1, 1'b1, 6'd36, 1'b1, 6'd0, 1'b0, 1'b1, ns, t);
    present(LD, 6'd1, 1'b1, 6'd0, 1'b0, 6'd32, 1'b1, 1'b0, ns, t1);
    check("R9 scheduled iteration", t1 - t0, 6);
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule